// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed static memory against corruption while the supply is lost or recovering. It takes digital supply-status flags from external comparators: two grade-specific "supply valid" flags and a "supply above switchover level" flag. A one-hot state machine (NORMAL, PROTECT, BATTERY, RECOVER) acts on them. The host chip-enable, write-enable and output-enable strobes reach the array only in NORMAL. In every other state the strobes are forced inactive, writes are inhibited and a tristate request goes out to the data drivers.

When the supply falls below the switchover level, the block selects the backup source. When the supply becomes valid again, write protection is held for a recovery interval before host access is restored. A prescaler produces a 1 ms tick from the free-running clock, and a tick counter measures that interval. Any dip during recovery restarts the interval from zero. A one-time latch arms the backup source on the first valid supply. A sticky flag records power-fail events until the host acknowledges it. The state reaches the host on a status output.

Top module: `pwr_guard`

## Requirements
- R1: After reset, state_o reads 4'b0100 (bit0 NORMAL, bit1 PROTECT, bit2 BATTERY, bit3 RECOVER). In this state batt_sel_o, wr_inhibit_o and out_hiz_o are 1, batt_arm_o and fail_seen_o are 0, and the array strobes are 1.
- R2: When the selected supply-valid flag falls in NORMAL, the state is still NORMAL after the 2nd rising edge and is PROTECT after the 3rd edge. From then on the array strobes are high whatever the host drives. At 4 ns per cycle this is far inside the 1.5 µs limit.
- R3: In every state other than NORMAL, all eight combinations of host ce/we/oe leave arr_ce_n_o, arr_we_n_o and arr_oe_n_o at 1, with wr_inhibit_o=1 and out_hiz_o=1.
- R4: In NORMAL, each array strobe equals its host strobe for all eight combinations, and wr_inhibit_o=0 and out_hiz_o=0.
- R5: When the switchover flag falls in PROTECT, the state becomes BATTERY (batt_sel_o=1) at the 3rd edge. When it rises in BATTERY, the state leaves BATTERY at the 3rd edge: to RECOVER if the supply is valid, otherwise to PROTECT.
- R6: A valid flag that rises in PROTECT gives RECOVER at the 3rd edge. NORMAL follows exactly TICK_CYC*REC_TICKS+1 cycles after RECOVER is entered, and strobes stay inactive throughout. The defaults are 1 ms ticks and 125 ticks.
- R7: A valid flag that falls during RECOVER gives PROTECT at the 3rd edge. The next entry into RECOVER times the full interval again from zero.
- R8: batt_arm_o is 0 until the selected valid flag is first seen. It is 1 by the 3rd edge after that flag rises, and it never returns to 0 until reset.
- R9: With GRADE_WIDE=0 the block follows vok_tight_i and ignores vok_wide_i. With GRADE_WIDE=1 it follows vok_wide_i and ignores vok_tight_i.
- R10: fail_seen_o sets on each NORMAL-to-PROTECT transition and clears one edge after an ack_i pulse. If both happen at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vok_tight_i | input | 1 | Supply valid, 5% grade comparator |
| vok_wide_i | input | 1 | Supply valid, 10% grade comparator |
| vsw_i | input | 1 | Supply above battery switchover level |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| ack_i | input | 1 | Clears the power-fail flag |
| arr_ce_n_o | output | 1 | Gated chip enable to array |
| arr_we_n_o | output | 1 | Gated write enable to array |
| arr_oe_n_o | output | 1 | Gated output enable to array |
| wr_inhibit_o | output | 1 | Write protection active |
| out_hiz_o | output | 1 | Request tristate on data outputs |
| batt_sel_o | output | 1 | Run array from backup source |
| batt_arm_o | output | 1 | One-time backup enable seal |
| fail_seen_o | output | 1 | Sticky power-fail event flag |
| state_o | output | 4 | One-hot state |

## Verification
Every flag change reaches the state three edges later: two synchronizer flops and then the state register. The strobe gating is combinational from the state. The bench drives inputs on falling edges and samples both one edge before and exactly at the third edge, which pins the latency exactly. The recovery exit is checked one cycle before and on the predicted cycle TICK_CYC*REC_TICKS+1 after RECOVER is entered. The flag and the arming latch are checked one edge after the edge that sets or clears them.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [3:0] {
    ST_NORMAL  = 4'b0001,
    ST_PROTECT = 4'b0010,
    ST_BATTERY = 4'b0100,
    ST_RECOVER = 4'b1000
  } pg_state_e;

  localparam int unsigned IX_NORMAL  = 0;
  localparam int unsigned IX_PROTECT = 1;
  localparam int unsigned IX_BATTERY = 2;
  localparam int unsigned IX_RECOVER = 3;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pg_timer.sv
module pg_timer #(
  parameter int unsigned TICK_CYC  = 250000,
  parameter int unsigned REC_TICKS = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int unsigned RW = $clog2(REC_TICKS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(TICK_CYC - 1);
  localparam logic [RW-1:0] R_END  = RW'(REC_TICKS);

  logic [PW-1:0] presc_q;
  logic [RW-1:0] rec_q;
  logic          tick;

  assign tick = run_i && (presc_q == P_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      rec_q   <= '0;
    end else if (!run_i) begin
      presc_q <= '0;
      rec_q   <= '0;
    end else begin
      presc_q <= tick ? '0 : presc_q + 1'b1;
      if (tick && rec_q != R_END) rec_q <= rec_q + 1'b1; // saturate
    end
  end

  assign done_o = (rec_q == R_END);
endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
  import pg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vok_i,
  input  logic       vsw_i,
  input  logic       done_i,
  input  logic       ack_i,
  output logic [3:0] state_o,
  output logic       arm_o,
  output logic       fail_o
);
  pg_state_e state_q, state_d;
  logic      arm_q, fail_q, fail_evt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:  if (!vok_i) state_d = ST_PROTECT;
      ST_PROTECT: begin
        if (!vsw_i)     state_d = ST_BATTERY;
        else if (vok_i) state_d = ST_RECOVER;
      end
      ST_BATTERY: if (vsw_i) state_d = vok_i ? ST_RECOVER : ST_PROTECT;
      ST_RECOVER: begin
        if (!vok_i)      state_d = ST_PROTECT; // restarts interval
        else if (done_i) state_d = ST_NORMAL;
      end
      default:    state_d = ST_PROTECT;
    endcase
  end

  assign fail_evt = (state_q == ST_NORMAL) && !vok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BATTERY;
      arm_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      arm_q   <= arm_q | vok_i;
      if (fail_evt)   fail_q <= 1'b1;
      else if (ack_i) fail_q <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign arm_o   = arm_q;
  assign fail_o  = fail_q;
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pg_pkg::*;
#(
  parameter bit          GRADE_WIDE = 1'b0,
  parameter int unsigned TICK_CYC   = 250000,
  parameter int unsigned REC_TICKS  = 125
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vok_tight_i,
  input  logic       vok_wide_i,
  input  logic       vsw_i,
  input  logic       host_ce_n_i,
  input  logic       host_we_n_i,
  input  logic       host_oe_n_i,
  input  logic       ack_i,
  output logic       arr_ce_n_o,
  output logic       arr_we_n_o,
  output logic       arr_oe_n_o,
  output logic       wr_inhibit_o,
  output logic       out_hiz_o,
  output logic       batt_sel_o,
  output logic       batt_arm_o,
  output logic       fail_seen_o,
  output logic [3:0] state_o
);
  logic       vok_raw;
  logic [1:0] flags_s;
  logic       done;
  logic [3:0] state;
  logic       normal;

  generate
    if (GRADE_WIDE) begin : g_wide
      assign vok_raw = vok_wide_i;
    end else begin : g_tight
      assign vok_raw = vok_tight_i;
    end
  endgenerate

  pg_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({vsw_i, vok_raw}),
    .q_o    (flags_s)
  );

  pg_timer #(.TICK_CYC(TICK_CYC), .REC_TICKS(REC_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state[IX_RECOVER]),
    .done_o (done)
  );

  pg_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vok_i   (flags_s[0]),
    .vsw_i   (flags_s[1]),
    .done_i  (done),
    .ack_i   (ack_i),
    .state_o (state),
    .arm_o   (batt_arm_o),
    .fail_o  (fail_seen_o)
  );

  assign normal       = state[IX_NORMAL];
  assign arr_ce_n_o   = host_ce_n_i | ~normal;
  assign arr_we_n_o   = host_we_n_i | ~normal;
  assign arr_oe_n_o   = host_oe_n_i | ~normal;
  assign wr_inhibit_o = ~normal;
  assign out_hiz_o    = ~normal;
  assign batt_sel_o   = state[IX_BATTERY];
  assign state_o      = state;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       arr_ce_n_o,
  input logic       arr_we_n_o,
  input logic       arr_oe_n_o,
  input logic       batt_sel_o,
  input logic       batt_arm_o,
  input logic       fail_seen_o,
  input logic [3:0] state_o
);
  // R1: state is always exactly one-hot
  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_o[0] |-> (arr_ce_n_o && arr_we_n_o && arr_oe_n_o));

  p_no_direct_batt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[0] |=> !batt_sel_o);

  p_normal_via_recover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o[0]) |-> $past(state_o[3]));

  p_arm_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_arm_o |=> batt_arm_o);

  p_fail_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_o[0]) |-> fail_seen_o);

  p_fail_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_seen_o && !ack_i) |=> fail_seen_o);
endmodule

bind pwr_guard pwr_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .arr_ce_n_o  (arr_ce_n_o),
  .arr_we_n_o  (arr_we_n_o),
  .arr_oe_n_o  (arr_oe_n_o),
  .batt_sel_o  (batt_sel_o),
  .batt_arm_o  (batt_arm_o),
  .fail_seen_o (fail_seen_o),
  .state_o     (state_o)
);

// File: tb/pwr_guard_test.sv
module pwr_guard_test;
  localparam int unsigned P = 4;
  localparam int unsigned R = 5;
  localparam logic [3:0] S_NOR = 4'b0001, S_PRO = 4'b0010, S_BAT = 4'b0100, S_REC = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vt = 1'b0, vw = 1'b0, vsw = 1'b0;
  logic ce = 1'b1, we = 1'b1, oe = 1'b1, ack = 1'b0;
  logic a_ce, a_we, a_oe, inh, hiz, bsel, arm, fail;
  logic [3:0] st;
  logic w_ce, w_we, w_oe, w_inh, w_hiz, w_bsel, w_arm, w_fail;
  logic [3:0] w_st;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_guard #(.GRADE_WIDE(1'b0), .TICK_CYC(P), .REC_TICKS(R)) uut (
    .clk_i(clk), .rst_ni(rst_n), .vok_tight_i(vt), .vok_wide_i(vw), .vsw_i(vsw),
    .host_ce_n_i(ce), .host_we_n_i(we), .host_oe_n_i(oe), .ack_i(ack),
    .arr_ce_n_o(a_ce), .arr_we_n_o(a_we), .arr_oe_n_o(a_oe), .wr_inhibit_o(inh),
    .out_hiz_o(hiz), .batt_sel_o(bsel), .batt_arm_o(arm), .fail_seen_o(fail),
    .state_o(st));

  pwr_guard #(.GRADE_WIDE(1'b1), .TICK_CYC(P), .REC_TICKS(R)) uut_wide (
    .clk_i(clk), .rst_ni(rst_n), .vok_tight_i(vt), .vok_wide_i(vw), .vsw_i(vsw),
    .host_ce_n_i(ce), .host_we_n_i(we), .host_oe_n_i(oe), .ack_i(ack),
    .arr_ce_n_o(w_ce), .arr_we_n_o(w_we), .arr_oe_n_o(w_oe), .wr_inhibit_o(w_inh),
    .out_hiz_o(w_hiz), .batt_sel_o(w_bsel), .batt_arm_o(w_arm), .fail_seen_o(w_fail),
    .state_o(w_st));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Host strobe sweep; gated=1 means outputs must be all-high
  task automatic sweep(input string req, input bit gated);
    for (int i = 0; i < 8; i++) begin
      {ce, we, oe} = 3'(i);
      #1;
      if (gated) check(req, {a_ce, a_we, a_oe, inh, hiz}, 5'b11111);
      else       check(req, {a_ce, a_we, a_oe, inh, hiz}, {3'(i), 2'b00});
    end
    {ce, we, oe} = 3'b111;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state", st, S_BAT);
    check("R1 outs", {bsel, inh, hiz, arm, fail, a_ce, a_we, a_oe}, 8'b11100111);

    vsw = 1'b1;
    step(2); check("R5 leave-batt early", st, S_BAT);
    step(1); check("R5 leave-batt to protect", st, S_PRO);
    check("R5 batt_sel low", bsel, 1'b0);
    check("R8 arm clear before valid", arm, 1'b0);
    sweep("R3 protect sweep", 1'b1);

    vt = 1'b1; vw = 1'b1;
    step(3); check("R6 enter recover", st, S_REC);
    check("R8 arm set", arm, 1'b1);
    sweep("R3 recover sweep", 1'b1);
    step(10 - 1);
    vt = 1'b0; vw = 1'b0;
    step(3); check("R7 dip to protect", st, S_PRO);
    vt = 1'b1; vw = 1'b1;
    step(3); check("R7 re-enter recover", st, S_REC);
    step(R * P); check("R7 full interval still recover", st, S_REC);
    step(1); check("R7 normal after full interval", st, S_NOR);
    check("R9 wide instance normal", w_st, S_NOR);
    sweep("R4 normal sweep", 1'b0);

    ce = 1'b0; we = 1'b0; oe = 1'b0;
    vt = 1'b0; vw = 1'b0;
    step(2); check("R2 still normal at edge 2", st, S_NOR);
    step(1); check("R2 protect at edge 3", st, S_PRO);
    check("R2 strobes forced", {a_ce, a_we, a_oe, inh, hiz}, 5'b11111);
    check("R10 fail set", fail, 1'b1);
    ce = 1'b1; we = 1'b1; oe = 1'b1;
    ack = 1'b1; step(1); ack = 1'b0;
    check("R10 fail cleared by ack", {fail, w_fail}, 2'b00);

    vsw = 1'b0;
    step(2); check("R5 still protect", st, S_PRO);
    step(1); check("R5 enter battery", {st, bsel}, {S_BAT, 1'b1});
    sweep("R3 battery sweep", 1'b1);
    vsw = 1'b1;
    step(3); check("R5 battery to protect", {st, bsel}, {S_PRO, 1'b0});
    check("R8 arm sticky", arm, 1'b1);

    vt = 1'b1; vw = 1'b1;
    step(3); check("R6 enter recover", st, S_REC);
    step(R * P); check("R6 one cycle before exit", {st, a_we}, {S_REC, 1'b1});
    step(1); check("R6 exit to normal", st, S_NOR);

    vt = 1'b0;
    step(3); check("R9 tight instance protects", st, S_PRO);
    check("R9 wide instance ignores tight flag", {w_st, w_fail}, {S_NOR, 1'b0});
    check("R10 fail set again", fail, 1'b1);
    vt = 1'b1; vw = 1'b0;
    step(3); check("R9 tight instance ignores wide flag", st, S_REC);
    check("R9 wide instance protects", w_st, S_PRO);
    check("R8 arm still set", {arm, w_arm}, 2'b11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule